// File: doc/BRIEF.md
# DRAM Refresh Row-Address Extender

This block widens the reach of a video controller's built-in DRAM refresh. The controller refreshes by driving its own refresh counter onto the low row-address lines, but that counter only spans the low 8 row bits (256 rows). A DRAM array built from larger parts needs one or more extra row bits cycled as well. Without them, part of the array is never refreshed.

The extender watches the active-low bus-available strobe. When the strobe goes low, the controller issues its refresh accesses first, one per clock, and its video fetches after them. For the first `SLOTS` cycles of each low window, the block replaces the low `EXT_W` bits of the high row-address field with its own counter. In every other cycle it passes the normal high address through unchanged, so video data comes from the right place. The counter steps once each time the controller's refresh address wraps from all ones to zero. Over many raster lines, every combination of the low and extra row bits is visited.

The block has no data stream, so it has no valid/ready handshake. All pins are plain control and address lines. `row_hi` is a combinational mux output that is settled within the cycle in which `bus_avail`, `ref_lo` and `norm_hi` are presented. All registers are sampled on the rising clock edge.

Top module: `rrx_row_extender`

## Requirements
- R1: While `rst_n` is low, `row_hi` equals `norm_hi` whatever `bus_avail` is. After reset the extra counter is zero, so the first refresh slot drives zeros on the low `EXT_W` bits of `row_hi`.
- R2: In any cycle with `bus_avail` high, `row_hi` equals `norm_hi`.
- R3: Within the first `SLOTS` (default 5) cycles of a window with `bus_avail` low, `row_hi[EXT_W-1:0]` carries the extra counter and `row_hi[HI_W-1:EXT_W]` equals `norm_hi[HI_W-1:EXT_W]`.
- R4: From cycle `SLOTS+1` of a low window until `bus_avail` rises, `row_hi` equals `norm_hi`.
- R5: One rising edge that samples `bus_avail` high restarts the slot count. A window cut short before `SLOTS` cycles is therefore followed by a full `SLOTS` override cycles in the next window.
- R6: When a refresh slot presents `ref_lo` = 0 and the previous refresh slot presented `ref_lo` = all ones (0xFF), the extra counter advances by one. The advanced value already drives `row_hi` in that same slot.
- R7: `ref_lo` values outside refresh slots (idle or fetch cycles) are ignored. They neither advance the counter nor count as the "previous refresh slot" for R6.
- R8: The extra counter wraps modulo 2^`EXT_W`. With a sequential refresh address, all 2^(8+`EXT_W`) combined row values appear within ceil(2^(8+`EXT_W`)/5) windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one refresh slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_avail | input | 1 | Bus-available strobe; low marks a refresh-then-fetch window |
| ref_lo | input | LO_W (8) | Low row address driven by the controller (refresh counter during slots) |
| norm_hi | input | HI_W (4) | Normal high address bits from the system |
| row_hi | output | HI_W (4) | High address bits sent to the DRAM |

## Verification
The counter advance and the override can land in the same cycle. They meet when the refresh address reaches zero inside a slot, so the just-incremented value must appear on `row_hi` in that very slot. Because 256 is not a multiple of five, a long sequential sweep moves the all-ones/zero pair across every slot position. In one case the 0xFF falls in the last slot of one line and the 0x00 in the first slot of the next, with fetch cycles in between that drive decoy 0xFF/0x00 values. Each slot is judged against the arithmetic expectation `(n >> 8) mod 2^EXT_W` for the n-th refresh slot since reset.

// File: rtl/rrx_pkg.sv
package rrx_pkg;

  // Phase of the current bus cycle as seen by the extender.
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,  // strobe high, normal access
    PH_REFRESH = 2'd1,  // strobe low, inside the override slots
    PH_FETCH   = 2'd2   // strobe low, past the override slots
  } phase_e;

endpackage

// File: rtl/rrx_slot_tracker.sv
module rrx_slot_tracker
  import rrx_pkg::*;
#(
  parameter int SLOTS = 5
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bus_avail,
  output phase_e phase,
  output logic   in_slot
);

  localparam int CW = $clog2(SLOTS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SLOTS);

  logic [CW-1:0] cnt_q;

  // Override only while out of reset, strobe low and slots remain.
  assign in_slot = rst_n && !bus_avail && (cnt_q < LIMIT);

  always_comb begin
    if (bus_avail)    phase = PH_IDLE;
    else if (in_slot) phase = PH_REFRESH;
    else              phase = PH_FETCH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (bus_avail)      cnt_q <= '0;
    else if (cnt_q < LIMIT)  cnt_q <= cnt_q + CW'(1);
  end

  // R4: the slot count saturates and never exceeds its limit
  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R5: a sampled high strobe restarts the window
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    bus_avail |=> (cnt_q == '0));

  // R4: once in fetch, stay there until the strobe rises
  a_r4_fetch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH) |=> (bus_avail || phase == PH_FETCH));

endmodule

// File: rtl/rrx_ext_counter.sv
module rrx_ext_counter #(
  parameter int LO_W  = 8,
  parameter int EXT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_slot,
  input  logic [LO_W-1:0]  ref_lo,
  output logic [EXT_W-1:0] ext_now
);

  localparam logic [LO_W-1:0] LO_TOP = {LO_W{1'b1}};

  logic [LO_W-1:0]  last_q;   // refresh address of the previous slot
  logic [EXT_W-1:0] ext_q;
  logic             wrap;

  // Wrap seen in this slot: the new extra value is used at once.
  assign wrap    = in_slot && (ref_lo == '0) && (last_q == LO_TOP);
  assign ext_now = wrap ? ext_q + EXT_W'(1) : ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      ext_q  <= '0;
    end else if (in_slot) begin
      last_q <= ref_lo;
      ext_q  <= ext_now;
    end
  end

  // R6: a wrap slot moves the counter on by exactly one
  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slot && ref_lo == '0 && last_q == LO_TOP) |=>
      (ext_q == EXT_W'($past(ext_q) + EXT_W'(1))));

  // R7: addresses outside refresh slots leave all state alone
  a_r7_ignore_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !in_slot |=> ($stable(ext_q) && $stable(last_q)));

  // R8: the counter only ever holds or steps by one (modulo wrap)
  a_r8_step_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ext_q == $past(ext_q) || ext_q == EXT_W'($past(ext_q) + EXT_W'(1))));

endmodule

// File: rtl/rrx_addr_mux.sv
module rrx_addr_mux #(
  parameter int HI_W  = 4,
  parameter int EXT_W = 1
) (
  input  logic             override,
  input  logic [HI_W-1:0]  norm_hi,
  input  logic [EXT_W-1:0] ext_now,
  output logic [HI_W-1:0]  row_hi
);

  // Low part of the high field: counter during slots, else system address.
  assign row_hi[EXT_W-1:0] = override ? ext_now : norm_hi[EXT_W-1:0];

  // Remaining upper bits always pass through.
  generate
    if (HI_W > EXT_W) begin : g_upper
      assign row_hi[HI_W-1:EXT_W] = norm_hi[HI_W-1:EXT_W];
    end
  endgenerate

endmodule

// File: rtl/rrx_row_extender.sv
module rrx_row_extender
  import rrx_pkg::*;
#(
  parameter int LO_W  = 8,
  parameter int EXT_W = 1,
  parameter int HI_W  = 4,
  parameter int SLOTS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_avail,
  input  logic [LO_W-1:0] ref_lo,
  input  logic [HI_W-1:0] norm_hi,
  output logic [HI_W-1:0] row_hi
);

  phase_e           phase;
  logic             in_slot;
  logic [EXT_W-1:0] ext_now;

  rrx_slot_tracker #(.SLOTS(SLOTS)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_avail (bus_avail),
    .phase     (phase),
    .in_slot   (in_slot)
  );

  rrx_ext_counter #(.LO_W(LO_W), .EXT_W(EXT_W)) u_ext (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_slot (in_slot),
    .ref_lo  (ref_lo),
    .ext_now (ext_now)
  );

  rrx_addr_mux #(.HI_W(HI_W), .EXT_W(EXT_W)) u_mux (
    .override (in_slot),
    .norm_hi  (norm_hi),
    .ext_now  (ext_now),
    .row_hi   (row_hi)
  );

  // R2: strobe high means plain pass-through
  a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    bus_avail |-> (row_hi == norm_hi));

  // R4: fetch cycles present the system address
  a_r4_fetch_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH) |-> (row_hi == norm_hi));

  generate
    if (HI_W > EXT_W) begin : g_upper_chk
      // R3: bits above the extra field are never overridden
      a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_REFRESH) |-> (row_hi[HI_W-1:EXT_W] == norm_hi[HI_W-1:EXT_W]));
    end
  endgenerate

endmodule

// File: tb/rrx_row_extender_tb.sv
module rrx_row_extender_tb;

  localparam int LO    = 8;
  localparam int EXT   = 1;
  localparam int HI    = 4;
  localparam int SLOTS = 5;
  localparam int FETCH = 7;
  localparam int IDLE  = 3;
  localparam int ROWS  = 1 << (LO + EXT);
  localparam int LINES_FULL = (ROWS + SLOTS - 1) / SLOTS;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_avail;
  logic [LO-1:0] ref_lo;
  logic [HI-1:0] norm_hi;
  wire  [HI-1:0] row_hi;

  int vec = 0;
  int bad = 0;
  int slot_n = 0;       // refresh slots issued since last reset
  logic seen [ROWS];

  always #10 clk = ~clk;  // 50 MHz

  rrx_row_extender #(.LO_W(LO), .EXT_W(EXT), .HI_W(HI), .SLOTS(SLOTS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_avail(bus_avail),
    .ref_lo(ref_lo), .norm_hi(norm_hi), .row_hi(row_hi)
  );

  // One cycle: drive after the falling edge, check mid low phase.
  task automatic cyc(input logic b, input logic [LO-1:0] lo, input logic [HI-1:0] nh,
                     input logic ovr, input logic [EXT-1:0] ex, input string req);
    logic [HI-1:0] exp;
    @(negedge clk);
    bus_avail = b; ref_lo = lo; norm_hi = nh;
    #4;
    exp = ovr ? {nh[HI-1:EXT], ex} : nh;
    vec++;
    if (row_hi !== exp) begin
      bad++;
      $display("FAIL %s: row_hi=%h expected %h (slot %0d)", req, row_hi, exp, slot_n);
    end
  endtask

  function automatic logic [HI-1:0] pat(input int k);
    return HI'(k * 7 + 3);
  endfunction

  // One refresh slot with a sequential refresh address.
  task automatic rslot(input int pos);
    logic [LO-1:0]  lo;
    logic [EXT-1:0] ex;
    string req;
    lo = LO'(slot_n % (1 << LO));
    ex = EXT'((slot_n >> LO) % (1 << EXT));   // R8: modulo counter
    if (lo == '0 && slot_n != 0) req = "R6";
    else if (pos == 0)           req = "R7";
    else                         req = "R3";
    seen[slot_n % ROWS] = 1'b1;
    cyc(1'b0, lo, pat(vec), 1'b1, ex, req);
    slot_n++;
  endtask

  // A full raster-line window: idle, SLOTS refresh slots, fetch cycles.
  task automatic line();
    for (int i = 0; i < IDLE; i++) cyc(1'b1, LO'(i * 37), pat(vec), 1'b0, '0, "R2");
    for (int i = 0; i < SLOTS; i++) rslot(i);
    // R4 pass-through; R7 decoy wrap values on fetch cycles
    for (int i = 0; i < FETCH; i++)
      cyc(1'b0, (i % 2 == 0) ? 8'hFF : 8'h00, pat(vec), 1'b0, '0, "R4");
  endtask

  initial begin
    #(20 * 20000);
    bad++;
    $display("FAIL R8: watchdog expired, actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int missing;
    for (int i = 0; i < ROWS; i++) seen[i] = 1'b0;
    rst_n = 1'b0; bus_avail = 1'b1; ref_lo = '0; norm_hi = '0;
    // R1: reset forces pass-through even with the strobe low
    cyc(1'b1, 8'h00, 4'hA, 1'b0, '0, "R1");
    cyc(1'b0, 8'h00, 4'h5, 1'b0, '0, "R1");
    cyc(1'b0, 8'hFF, 4'hF, 1'b0, '0, "R1");
    @(negedge clk); bus_avail = 1'b1; rst_n = 1'b1;

    // R8: full coverage within the predicted number of lines
    for (int l = 0; l < LINES_FULL; l++) line();
    missing = 0;
    for (int i = 0; i < ROWS; i++) if (!seen[i]) missing++;
    vec++;
    if (missing != 0) begin
      bad++;
      $display("FAIL R8: %0d rows unvisited expected 0", missing);
    end

    // R6/R8: keep sweeping through counter wrap and a line-crossing wrap
    for (int l = LINES_FULL; l < 262; l++) line();

    // R5: short window, then a fresh full window
    cyc(1'b1, 8'h11, pat(vec), 1'b0, '0, "R5");
    rslot(1); rslot(2);
    cyc(1'b1, 8'h22, pat(vec), 1'b0, '0, "R5");
    for (int i = 0; i < SLOTS; i++) rslot(i);
    cyc(1'b0, 8'h33, pat(vec), 1'b0, '0, "R5");

    // R1: reset mid-run clears the extra counter (it was odd here)
    @(negedge clk); rst_n = 1'b0;
    cyc(1'b0, 8'h44, 4'h9, 1'b0, '0, "R1");
    @(negedge clk); rst_n = 1'b1; bus_avail = 1'b1;
    slot_n = 0;
    line();

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule